// File: doc/BRIEF.md
# Serial PHY Frame Deframer with CRC-16 Check

The block takes the recovered bit stream of a low-rate wireless PHY, one bit for each strobe, and turns it back into frames. It hunts for a synchronization header: a run of zero bits at least 32 long, then the 8-bit delimiter 0xA7. It then reads one header octet that carries the payload length. The payload octets come out one at a time on a byte-wide port, with markers on the first and last octet.

While the payload streams through, a bit-serial CRC-16 runs over every payload bit, including the two trailing check octets. When the last octet leaves, the block reports whether the residue is zero. A header whose length cannot hold even a minimal frame is flagged and dropped. The block then returns to hunting.

The input arrives at a slow strobe rate and cannot be stalled, so neither side has back-pressure. Each output octet is valid for exactly one clock cycle, and the consumer must take it in that cycle. Between two output octets there are always at least seven idle cycles.

Top module: `phy_deframer`

## Requirements
- R1: After synchronous reset, byte_valid, sof, eof, fcs_ok and len_err are all low, and no octet is emitted until a full synchronization header has been received.
- R2: Sync is declared only after at least 32 consecutive zero bits followed by 0xA7, sent least significant bit first (1,1,1,0,0,1,0,1). A run of 31 zeros before the delimiter gives no frame. A longer zero run is accepted.
- R3: A mismatch part-way through the preamble or delimiter restarts the hunt. The bit that caused the mismatch counts as the first bit of the new attempt, so 32 zeros counted from that bit, then the delimiter, are enough.
- R4: The octet after the delimiter is the header. Its bits 6..0 (bit 0 arriving first) give the payload length in octets. Its bit 7 is reserved and has no effect.
- R5: A length below 5 raises len_err for one cycle, one cycle after the header's last bit. No octet is emitted for that frame, and the hunt resumes at once.
- R6: Exactly length payload octets are emitted, each assembled with its first-arriving bit as bit 0. byte_valid pulses for one cycle, in the cycle after the strobe that delivered the octet's eighth bit.
- R7: sof is high together with byte_valid on the first payload octet only. eof is high together with byte_valid on the last payload octet only.
- R8: fcs_ok is sampled with eof. It is high when a CRC-16 (generator x^16+x^12+x^5+1, initial value 0) leaves a zero residue after running over all payload bits in arrival order, the check octets included. Otherwise it is low. The CRC is computed in right-shifting form with the constant 0x8408, and the low check octet is sent first.
- R9: Cycles with bit_valid low are ignored whatever bit_in holds, so idle gaps of any length between strobes do not change the output.
- R10: The length bounds 5 and 127 are both received in full.
- R11: After eof, or after len_err, the next frame is found with no extra idle time needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: bit_in carries a new bit this cycle |
| bit_in | input | 1 | Recovered serial bit |
| byte_valid | output | 1 | One-cycle pulse: byte_out holds a payload octet |
| byte_out | output | 8 | Payload octet |
| sof | output | 1 | Marks the first payload octet |
| eof | output | 1 | Marks the last payload octet |
| fcs_ok | output | 1 | CRC residue zero, valid with eof |
| len_err | output | 1 | One-cycle pulse: header length too small |

## Verification
Random frames vary the length, the preamble length, the data octets and the idle gaps between strobes. Idle gaps with a random bit_in separate sampling on the strobe from sampling on the clock. A single flipped bit in some random frames separates a real residue test from a constant pass. The directed cases cover: the 31/32 zero boundary, which shows that the preamble count is exact; a false start followed by exactly 32 zeros, which shows that the mismatching bit is not lost; length 3 followed at once by a good frame, which checks the error path and the return to the hunt; and lengths 5 and 127 together with a set reserved bit, which check the length field.

// File: rtl/phy_deframer_pkg.sv
package phy_deframer_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HDR  = 2'd1,
    ST_BODY = 2'd2
  } dfr_state_t;
endpackage

// File: rtl/deframe_sync_hunt.sv
// Sliding window over the last DELIM_W bits plus a count of zero bits
// that have left the window. A hit needs the window to equal DELIM and
// at least PRE_BITS zeros just before it, so no bit is ever dropped.
module deframe_sync_hunt #(
  parameter int          PRE_BITS = 32,
  parameter int          DELIM_W  = 8,
  parameter logic [7:0]  DELIM    = 8'hA7
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift,
  input  logic bit_in,
  output logic found
);
  localparam int RUN_W = $clog2(PRE_BITS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PRE_BITS);

  logic [DELIM_W-1:0] win_q, win_next;
  logic [RUN_W-1:0]   run_q, run_next;

  always_comb begin
    win_next = {bit_in, win_q[DELIM_W-1:1]};
    if (win_q[0])
      run_next = '0;
    else if (run_q >= RUN_MAX)
      run_next = run_q;
    else
      run_next = run_q + 1'b1;
    found = shift && (win_next == DELIM[DELIM_W-1:0]) && (run_next >= RUN_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      win_q <= '1;
      run_q <= '0;
    end else if (shift) begin
      win_q <= win_next;
      run_q <= run_next;
    end
  end
endmodule

// File: rtl/deframe_crc_serial.sv
// Bit-serial CRC in right-shifting form; exposes whether the value
// after the current bit is zero.
module deframe_crc_serial #(
  parameter int              CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'h8408
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  input  logic bit_in,
  output logic zero_next
);
  logic [CRC_W-1:0] crc_q, crc_step;

  always_comb begin
    crc_step = {1'b0, crc_q[CRC_W-1:1]};
    if (crc_q[0] ^ bit_in)
      crc_step = crc_step ^ POLY_REFL;
    zero_next = (crc_step == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      crc_q <= '0;
    else if (en)
      crc_q <= crc_step;
  end
endmodule

// File: rtl/deframe_bit_pack.sv
// Collects WORD_W bits, first bit into bit 0.
module deframe_bit_pack #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift,
  input  logic              bit_in,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    word = {bit_in, sr_q[WORD_W-1:1]};
    done = shift && (cnt_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift) begin
      sr_q  <= word;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/phy_deframer.sv
module phy_deframer
  import phy_deframer_pkg::*;
#(
  parameter int               PRE_BITS  = 32,
  parameter logic [7:0]       DELIM     = 8'hA7,
  parameter int               OCT_W     = 8,
  parameter int               LEN_W     = 7,
  parameter int               MIN_LEN   = 5,
  parameter int               CRC_W     = 16,
  parameter logic [15:0]      CRC_POLY  = 16'h8408
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             byte_valid,
  output logic [OCT_W-1:0] byte_out,
  output logic             sof,
  output logic             eof,
  output logic             fcs_ok,
  output logic             len_err
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  dfr_state_t       st_q;
  logic [LEN_W-1:0] rem_q;
  logic             first_q;

  logic             sync_found;
  logic             pack_done;
  logic [OCT_W-1:0] pack_word;
  logic             crc_zero;
  logic             in_hunt, in_body;
  logic [LEN_W-1:0] hdr_len;

  assign in_hunt = (st_q == ST_HUNT);
  assign in_body = (st_q == ST_BODY);
  assign hdr_len = pack_word[LEN_W-1:0];

  deframe_sync_hunt #(
    .PRE_BITS (PRE_BITS),
    .DELIM_W  (8),
    .DELIM    (DELIM)
  ) u_hunt (
    .clk    (clk),
    .rst    (rst),
    .clear  (!in_hunt),
    .shift  (bit_valid && in_hunt),
    .bit_in (bit_in),
    .found  (sync_found)
  );

  deframe_bit_pack #(
    .WORD_W (OCT_W)
  ) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clear  (in_hunt),
    .shift  (bit_valid && !in_hunt),
    .bit_in (bit_in),
    .done   (pack_done),
    .word   (pack_word)
  );

  deframe_crc_serial #(
    .CRC_W     (CRC_W),
    .POLY_REFL (CRC_POLY[CRC_W-1:0])
  ) u_crc (
    .clk       (clk),
    .rst       (rst),
    .clear     (!in_body),
    .en        (bit_valid && in_body),
    .bit_in    (bit_in),
    .zero_next (crc_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_HUNT;
      rem_q      <= '0;
      first_q    <= 1'b0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
      sof        <= 1'b0;
      eof        <= 1'b0;
      fcs_ok     <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      sof        <= 1'b0;
      eof        <= 1'b0;
      fcs_ok     <= 1'b0;
      len_err    <= 1'b0;
      unique case (st_q)
        ST_HUNT: begin
          if (sync_found) st_q <= ST_HDR;
        end
        ST_HDR: begin
          if (pack_done) begin
            if (hdr_len < LEN_MIN) begin
              len_err <= 1'b1;
              st_q    <= ST_HUNT;
            end else begin
              rem_q   <= hdr_len;
              first_q <= 1'b1;
              st_q    <= ST_BODY;
            end
          end
        end
        ST_BODY: begin
          if (pack_done) begin
            byte_valid <= 1'b1;
            byte_out   <= pack_word;
            sof        <= first_q;
            first_q    <= 1'b0;
            rem_q      <= rem_q - 1'b1;
            if (rem_q == LEN_ONE) begin
              eof    <= 1'b1;
              fcs_ok <= crc_zero;
              st_q   <= ST_HUNT;
            end
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/phy_deframer_chk.sv
module phy_deframer_chk (
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic byte_valid,
  input logic sof,
  input logic eof,
  input logic fcs_ok,
  input logic len_err
);
  p_sof_in_byte_r7: assert property (@(posedge clk) disable iff (rst)
    sof |-> byte_valid);
  p_eof_in_byte_r7: assert property (@(posedge clk) disable iff (rst)
    eof |-> byte_valid);
  p_fcs_with_eof_r8: assert property (@(posedge clk) disable iff (rst)
    fcs_ok |-> eof);
  p_lenerr_no_byte_r5: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !byte_valid);
  p_lenerr_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    len_err |-> $past(bit_valid));
  p_byte_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> $past(bit_valid));
  p_byte_single_r6: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);
endmodule

bind phy_deframer phy_deframer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_valid  (bit_valid),
  .byte_valid (byte_valid),
  .sof        (sof),
  .eof        (eof),
  .fcs_ok     (fcs_ok),
  .len_err    (len_err)
);

// File: tb/sim_phy_deframer.sv
`timescale 1ns/1ps
module sim_phy_deframer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       byte_valid, sof, eof, fcs_ok, len_err;
  logic [7:0] byte_out;

  always #5 clk = ~clk;

  phy_deframer u0 (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .byte_valid(byte_valid), .byte_out(byte_out), .sof(sof), .eof(eof),
    .fcs_ok(fcs_ok), .len_err(len_err)
  );

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   gaps_on = 1'b0;
  bit   done    = 1'b0;

  logic [7:0] tx [0:127];
  logic [7:0] rx_byte [0:255];
  bit         rx_sof [0:255];
  bit         rx_eof [0:255];
  bit         rx_fcs [0:255];
  int         rx_n = 0;
  int         lerr_n = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid && rx_n < 256) begin
        rx_byte[rx_n] = byte_out;
        rx_sof[rx_n]  = sof;
        rx_eof[rx_n]  = eof;
        rx_fcs[rx_n]  = fcs_ok;
        rx_n++;
      end
      if (len_err) lerr_n++;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    c = c >> 1;
    if (fb) c = c ^ 16'h8408;
    return c;
  endfunction

  task automatic make_frame(input int n, input bit corrupt);
    logic [15:0] c;
    c = '0;
    for (int i = 0; i < n - 2; i++) begin
      tx[i] = 8'($urandom);
      for (int k = 0; k < 8; k++) c = crc_bit(c, tx[i][k]);
    end
    tx[n-2] = c[7:0];
    tx[n-1] = c[15:8];
    if (corrupt) begin
      int p;
      p = int'($urandom % 32'(n));
      tx[p] = tx[p] ^ (8'd1 << ($urandom % 8));
    end
  endtask

  task automatic send_bit(input logic b);
    int idle;
    bit_valid = 1'b1;
    bit_in    = b;
    @(negedge clk);
    bit_valid = 1'b0;
    idle = gaps_on ? int'($urandom % 4) : 0;
    for (int i = 0; i < idle; i++) begin
      bit_in = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) send_bit(v[k]);
  endtask

  task automatic send_frame(input int pre, input logic [7:0] hdr, input int n);
    for (int i = 0; i < pre; i++) send_bit(1'b0);
    send_byte(8'hA7);
    send_byte(hdr);
    for (int i = 0; i < n; i++) send_byte(tx[i]);
  endtask

  task automatic clear_mon();
    rx_n = 0;
    lerr_n = 0;
  endtask

  task automatic verify_frame(input int n, input bit good, input string tag);
    int mism, sofs, eofs;
    repeat (4) @(negedge clk);
    chk(rx_n == n, {tag, " R6 octet count"}, rx_n, n);
    mism = 0; sofs = 0; eofs = 0;
    for (int i = 0; i < rx_n && i < n; i++) begin
      if (rx_byte[i] != tx[i]) mism++;
    end
    for (int i = 0; i < rx_n; i++) begin
      if (rx_sof[i]) sofs++;
      if (rx_eof[i]) eofs++;
    end
    chk(mism == 0, {tag, " R6 octet values mismatches"}, mism, 0);
    chk(rx_n > 0 && rx_sof[0] && sofs == 1, {tag, " R7 sof count"}, sofs, 1);
    chk(rx_n > 0 && rx_eof[rx_n-1] && eofs == 1, {tag, " R7 eof count"}, eofs, 1);
    if (rx_n > 0)
      chk(rx_fcs[rx_n-1] == good, {tag, " R8 fcs_ok"}, int'(rx_fcs[rx_n-1]), int'(good));
    chk(lerr_n == 0, {tag, " R5 no len_err"}, lerr_n, 0);
    clear_mon();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({byte_valid, sof, eof, fcs_ok, len_err} == 5'b0, "R1 outputs after reset",
        int'({byte_valid, sof, eof, fcs_ok, len_err}), 0);
    // R9: bit_in toggling without strobes does nothing
    for (int i = 0; i < 60; i++) begin bit_in = 1'($urandom); @(negedge clk); end
    chk(rx_n == 0 && lerr_n == 0, "R9 no strobe no output", rx_n + lerr_n, 0);
    clear_mon();

    // R10 / R2: minimum length, exactly 32 zeros
    make_frame(5, 1'b0);
    send_frame(32, 8'd5, 5);
    verify_frame(5, 1'b1, "R10 len5");

    // R8: corrupted frame
    make_frame(12, 1'b1);
    send_frame(32, 8'd12, 12);
    verify_frame(12, 1'b0, "R8 bad fcs");

    // R10: maximum length
    make_frame(127, 1'b0);
    send_frame(36, 8'd127, 127);
    verify_frame(127, 1'b1, "R10 len127");

    // R5 / R11: short length then an immediate good frame
    make_frame(5, 1'b0);
    send_frame(32, 8'd3, 0);
    repeat (3) @(negedge clk);
    chk(lerr_n == 1, "R5 len_err pulses", lerr_n, 1);
    chk(rx_n == 0, "R5 no octets on short length", rx_n, 0);
    clear_mon();
    make_frame(7, 1'b0);
    send_frame(32, 8'd7, 7);
    verify_frame(7, 1'b1, "R11 after len_err");

    // R4: reserved header bit set
    make_frame(9, 1'b0);
    send_frame(32, 8'h80 | 8'd9, 9);
    verify_frame(9, 1'b1, "R4 reserved bit");

    // R2: only 31 zeros -> no frame
    make_frame(8, 1'b0);
    send_frame(31, 8'd8, 8);
    repeat (4) @(negedge clk);
    chk(rx_n == 0 && lerr_n == 0, "R2 31 zeros rejected", rx_n, 0);
    clear_mon();

    // R3: false delimiter start; mismatching zero begins the new run
    for (int i = 0; i < 35; i++) send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    make_frame(6, 1'b0);
    send_frame(32, 8'd6, 6);
    verify_frame(6, 1'b1, "R3 restart keeps bit");

    // R9 / R11: random frames, random gaps, some corrupted
    gaps_on = 1'b1;
    for (int f = 0; f < 20; f++) begin
      int n;
      bit bad;
      n   = 5 + int'($urandom % 36);
      bad = ($urandom % 3) == 0;
      make_frame(n, bad);
      send_frame(32 + int'($urandom % 8), 8'(n), n);
      verify_frame(n, !bad, "R9 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule